// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block is a single-port atomic execution unit with a small word-addressed memory inside it. A client hands it one request at a time over a valid/ready channel. Five operations are available: compare-and-swap, fetch-and-add, exchange, a double-word compare-and-swap on two adjacent words, and a compare-one-write-two form that checks a single word (typically a version counter) and replaces the pair on a match.

Each accepted request finishes without any chance of interference. The unit reads memory in the cycle after acceptance and writes in the next cycle. It holds `req_ready` low until the response has been taken, so no other access can fall between the read and the write. The response carries the prior memory contents and an equal flag, so a compare miss can be told apart from a successful swap. Requests that break the rules get an error flag and leave memory alone.

The memory is split into an even-word bank and an odd-word bank. This lets a double-word operation read and write both words of an aligned pair in a single cycle.

Top module: `amo_unit`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Compare-and-swap (`req_op`=0, `req_dw`=0) returns the old word in `rsp_old_lo` and 0 in `rsp_old_hi`. When the word equals `req_cmp_lo`, it writes `req_data_lo` and sets `rsp_equal`. Otherwise memory is unchanged and `rsp_equal` is 0.
- R3: Fetch-and-add (`req_op`=1, `req_dw`=0) returns the old word and stores old + `req_data_lo`, wrapping modulo 2^DATA_W. `rsp_equal` is 0.
- R4: Exchange (`req_op`=2, `req_dw`=0) returns the old word and stores `req_data_lo`. `rsp_equal` is 0.
- R5: Double-word compare-and-swap (`req_op`=0, `req_dw`=1) treats words A and A+1 as one unit. It returns them in `rsp_old_lo`/`rsp_old_hi`. Only when both match `req_cmp_lo`/`req_cmp_hi` does it write `req_data_lo`/`req_data_hi` and set `rsp_equal`.
- R6: Compare-one-write-two (`req_op`=3, with `req_dw` ignored) returns words A and A+1. It compares only word A with `req_cmp_lo`, and on a match writes both words and sets `rsp_equal`.
- R7: Add or exchange with `req_dw`=1 responds with `rsp_err`=1 and modifies no memory word.
- R8: A double-word operation (R5 or R6) at an odd address responds with `rsp_err`=1 and modifies no memory word.
- R9: `req_ready` is 0 from the edge that accepts a request until the edge that takes its response. `rsp_valid` rises at the first clock edge after acceptance.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold their values.
- R11: An error response carries `rsp_old_lo`=0, `rsp_old_hi`=0 and `rsp_equal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | 0 compare-swap, 1 add, 2 exchange, 3 compare-one-write-two |
| req_dw | input | 1 | Double-word form requested |
| req_addr | input | ADDR_W | Word index (pair base for double-word) |
| req_cmp_lo | input | DATA_W | Comparand for word A |
| req_cmp_hi | input | DATA_W | Comparand for word A+1 |
| req_data_lo | input | DATA_W | Swap value or addend for word A |
| req_data_hi | input | DATA_W | Swap value for word A+1 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_old_lo | output | DATA_W | Prior contents of word A |
| rsp_old_hi | output | DATA_W | Prior contents of word A+1 (0 for single-word) |
| rsp_equal | output | 1 | Compare matched and the write was done |
| rsp_err | output | 1 | Request rejected, memory untouched |

## Verification
A wrong bank select or pair mapping does not show up in the response that caused it. It shows up in the old value returned by the next operation that touches the same word, so the bench keeps a reference image of the memory and checks every returned old value against it. A corrupted control state shows at once as `req_ready` high during an operation, or as `rsp_valid` arriving on the wrong edge. Both of these are checked in the cycle after acceptance. Rejected requests are followed later by accesses to the same words, which would expose any stray write.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [1:0] {
    OP_CAS  = 2'd0,
    OP_ADD  = 2'd1,
    OP_XCHG = 2'd2,
    OP_CW2  = 2'd3
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_RESP = 2'd2
  } amo_state_e;

endpackage

// File: rtl/amo_bank.sv
module amo_bank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_row] <= wr_data;
    rd_data <= store[rd_row];
  end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amo_op_e           op,
  input  logic              dw,
  input  logic              odd,
  input  logic [DATA_W-1:0] bank_even,
  input  logic [DATA_W-1:0] bank_odd,
  input  logic [DATA_W-1:0] cmp_lo,
  input  logic [DATA_W-1:0] cmp_hi,
  input  logic [DATA_W-1:0] dat_lo,
  input  logic [DATA_W-1:0] dat_hi,
  output logic              wr_even,
  output logic              wr_odd,
  output logic [DATA_W-1:0] wdata_even,
  output logic [DATA_W-1:0] wdata_odd,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic              res_eq,
  output logic              res_err
);

  logic              pair;
  logic [DATA_W-1:0] old_lo, old_hi, new_lo;
  logic              match, wr;

  always_comb begin
    pair    = (op == OP_CW2) || (op == OP_CAS && dw);
    res_err = (dw && (op == OP_ADD || op == OP_XCHG)) || (pair && odd);
    old_lo  = pair ? bank_even : (odd ? bank_odd : bank_even);
    old_hi  = pair ? bank_odd : '0;
    unique case (op)
      OP_CAS:  match = dw ? (old_lo == cmp_lo && old_hi == cmp_hi) : (old_lo == cmp_lo);
      OP_CW2:  match = (old_lo == cmp_lo);
      default: match = 1'b0;
    endcase
    new_lo = (op == OP_ADD) ? old_lo + dat_lo : dat_lo;
    wr     = !res_err && ((op == OP_ADD || op == OP_XCHG) ? 1'b1 : match);
    wr_even    = wr && (pair || !odd);
    wr_odd     = wr && (pair || odd);
    wdata_even = new_lo;
    wdata_odd  = pair ? dat_hi : new_lo;
    res_eq = match && !res_err;
    res_lo = res_err ? '0 : old_lo;
    res_hi = res_err ? '0 : old_hi;
  end

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic accept,
  output logic exec,
  output logic rsp_valid
);

  amo_state_e state;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign exec      = (state == ST_EXEC);
  assign rsp_valid = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE: if (req_valid) state <= ST_EXEC;
        ST_EXEC: state <= ST_RESP;
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_dw,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_cmp_lo,
  input  logic [DATA_W-1:0] req_cmp_hi,
  input  logic [DATA_W-1:0] req_data_lo,
  input  logic [DATA_W-1:0] req_data_hi,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_old_lo,
  output logic [DATA_W-1:0] rsp_old_hi,
  output logic              rsp_equal,
  output logic              rsp_err
);

  localparam int ROWS  = 2 ** (ADDR_W - 1);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int NBANK = 2;

  logic accept, exec;

  amo_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_ready(rsp_ready),
    .req_ready(req_ready), .accept(accept), .exec(exec), .rsp_valid(rsp_valid)
  );

  // latched request
  amo_op_e           q_op;
  logic              q_dw;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_cmp_lo, q_cmp_hi, q_dat_lo, q_dat_hi;

  always_ff @(posedge clk) begin
    if (accept) begin
      q_op     <= amo_op_e'(req_op);
      q_dw     <= req_dw;
      q_addr   <= req_addr;
      q_cmp_lo <= req_cmp_lo;
      q_cmp_hi <= req_cmp_hi;
      q_dat_lo <= req_data_lo;
      q_dat_hi <= req_data_hi;
    end
  end

  logic [ROW_W-1:0]  rd_row, wr_row;
  logic [DATA_W-1:0] rd_word [NBANK];
  logic [DATA_W-1:0] wr_word [NBANK];
  logic              wr_bank [NBANK];

  assign rd_row = req_ready ? ROW_W'(req_addr >> 1) : ROW_W'(q_addr >> 1);
  assign wr_row = ROW_W'(q_addr >> 1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    amo_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) u_bank (
      .clk(clk), .rd_row(rd_row), .rd_data(rd_word[b]),
      .wr_en(wr_bank[b] && exec), .wr_row(wr_row), .wr_data(wr_word[b])
    );
  end

  logic [DATA_W-1:0] res_lo, res_hi;
  logic              res_eq, res_err;
  logic              we_even, we_odd;
  logic [DATA_W-1:0] wd_even, wd_odd;

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op(q_op), .dw(q_dw), .odd(q_addr[0]),
    .bank_even(rd_word[0]), .bank_odd(rd_word[1]),
    .cmp_lo(q_cmp_lo), .cmp_hi(q_cmp_hi), .dat_lo(q_dat_lo), .dat_hi(q_dat_hi),
    .wr_even(we_even), .wr_odd(we_odd), .wdata_even(wd_even), .wdata_odd(wd_odd),
    .res_lo(res_lo), .res_hi(res_hi), .res_eq(res_eq), .res_err(res_err)
  );

  assign wr_bank[0] = we_even;
  assign wr_bank[1] = we_odd;
  assign wr_word[0] = wd_even;
  assign wr_word[1] = wd_odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_old_lo <= '0;
      rsp_old_hi <= '0;
      rsp_equal  <= 1'b0;
      rsp_err    <= 1'b0;
    end else if (exec) begin
      rsp_old_lo <= res_lo;
      rsp_old_hi <= res_hi;
      rsp_equal  <= res_eq;
      rsp_err    <= res_err;
    end
  end

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              req_dw,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_old_lo,
  input logic [DATA_W-1:0] rsp_old_hi,
  input logic              rsp_equal,
  input logic              rsp_err
);

  logic acc;
  assign acc = req_valid && req_ready;

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (req_ready && !rsp_valid));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> (!req_ready && !rsp_valid));

  a_r9_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> ##1 rsp_valid);

  a_r9_no_ready_with_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old_lo) && $stable(rsp_old_hi)
                                   && $stable(rsp_equal) && $stable(rsp_err)));

  a_r7_single_only: assert property (@(posedge clk) disable iff (rst)
    (acc && req_dw && (req_op == 2'd1 || req_op == 2'd2)) |=> ##1 rsp_err);

  a_r11_err_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_old_lo == '0 && rsp_old_hi == '0 && !rsp_equal));

endmodule

bind amo_unit amo_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_dw(req_dw), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_old_lo(rsp_old_lo), .rsp_old_hi(rsp_old_hi), .rsp_equal(rsp_equal), .rsp_err(rsp_err)
);

// File: tb/tb_amo_unit.sv
module tb_amo_unit;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int DEPTH = 2 ** AW;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, req_dw, rsp_valid, rsp_ready, rsp_equal, rsp_err;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_cmp_lo, req_cmp_hi, req_data_lo, req_data_hi, rsp_old_lo, rsp_old_hi;

  always #4 clk = ~clk;

  amo_unit #(.DATA_W(DW), .ADDR_W(AW)) dut (.*);

  int checks = 0;
  int bad = 0;
  logic [DW-1:0] model [DEPTH];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_err(input logic [1:0] op, input logic dw, input logic [AW-1:0] a);
    bit pair = (op == 2'd3) || (op == 2'd0 && dw);
    return (dw && (op == 2'd1 || op == 2'd2)) || (pair && a[0]);
  endfunction

  // reference: compute expected response and update the model
  task automatic ref_op(input logic [1:0] op, input logic dw, input logic [AW-1:0] a,
                        input logic [DW-1:0] cl, ch, dl, dh,
                        output logic [DW-1:0] elo, ehi, output logic eeq, eerr, output string tag);
    bit pair = (op == 2'd3) || (op == 2'd0 && dw);
    eerr = is_err(op, dw, a);
    elo = '0; ehi = '0; eeq = 1'b0;
    if (eerr) begin
      tag = (op == 2'd1 || op == 2'd2) ? "R7" : "R8";
      return;
    end
    if (pair) begin
      elo = model[a]; ehi = model[a + 1];
      eeq = (op == 2'd3) ? (elo == cl) : (elo == cl && ehi == ch);
      if (eeq) begin model[a] = dl; model[a + 1] = dh; end
      tag = (op == 2'd3) ? "R6" : "R5";
    end else begin
      elo = model[a];
      case (op)
        2'd0: begin eeq = (elo == cl); if (eeq) model[a] = dl; tag = "R2"; end
        2'd1: begin model[a] = elo + dl; tag = "R3"; end
        default: begin model[a] = dl; tag = "R4"; end
      endcase
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic dw, input logic [AW-1:0] a,
                       input logic [DW-1:0] cl, ch, dl, dh, input bit check_old);
    logic [DW-1:0] elo, ehi;
    logic eeq, eerr;
    string tag;
    int hold;
    ref_op(op, dw, a, cl, ch, dl, dh, elo, ehi, eeq, eerr, tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_dw = dw; req_addr = a;
    req_cmp_lo = cl; req_cmp_hi = ch; req_data_lo = dl; req_data_hi = dh;
    chk(req_ready === 1'b1, "R9 idle ready", DW'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R9 busy after accept", DW'({req_ready, rsp_valid}), 0);
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R9 response latency", DW'(rsp_valid), 1);
    chk(rsp_err === eerr, {tag, " err"}, DW'(rsp_err), DW'(eerr));
    if (check_old || eerr) begin
      chk(rsp_old_lo === elo, {tag, eerr ? " R11 old_lo" : " old_lo"}, rsp_old_lo, elo);
      chk(rsp_old_hi === ehi, {tag, eerr ? " R11 old_hi" : " old_hi"}, rsp_old_hi, ehi);
      chk(rsp_equal === eeq, {tag, " equal"}, DW'(rsp_equal), DW'(eeq));
    end
    hold = $urandom % 3;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_old_lo === elo | !(check_old || eerr) ? rsp_valid === 1'b1 : 1'b0,
          "R10 hold", rsp_old_lo, elo);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R9 ready after take", DW'({req_ready, rsp_valid}), 2);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b0;
    req_op = '0; req_dw = 1'b0; req_addr = '0;
    req_cmp_lo = '0; req_cmp_hi = '0; req_data_lo = '0; req_data_hi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset state", DW'({req_ready, rsp_valid}), 2);

    // fill memory through exchange (old contents unknown)
    for (int i = 0; i < DEPTH; i++) do_op(2'd2, 1'b0, AW'(i), '0, '0, DW'(32'h100 + i), '0, 1'b0);

    // directed corners
    do_op(2'd0, 1'b0, 4'd3, 32'h103, '0, 32'hAAAA, '0, 1'b1);        // R2 match
    do_op(2'd0, 1'b0, 4'd3, 32'h1234, '0, 32'hBBBB, '0, 1'b1);       // R2 miss
    do_op(2'd2, 1'b0, 4'd5, '0, '0, 32'hFFFF_FFFF, '0, 1'b1);        // R4
    do_op(2'd1, 1'b0, 4'd5, '0, '0, 32'd2, '0, 1'b1);                // R3 wrap
    do_op(2'd1, 1'b0, 4'd5, '0, '0, 32'd0, '0, 1'b1);                // R3 readback
    do_op(2'd0, 1'b1, 4'd8, 32'h108, 32'h109, 32'h11, 32'h22, 1'b1); // R5 match
    do_op(2'd0, 1'b1, 4'd8, 32'h11, 32'h99, 32'h33, 32'h44, 1'b1);   // R5 hi miss
    do_op(2'd3, 1'b0, 4'd8, 32'h11, 32'h77, 32'h55, 32'h66, 1'b1);   // R6 lo match only
    do_op(2'd1, 1'b1, 4'd10, '0, '0, 32'h5, '0, 1'b1);               // R7 add dw
    do_op(2'd2, 1'b1, 4'd10, '0, '0, 32'h5, 32'h6, 1'b1);            // R7 xchg dw
    do_op(2'd0, 1'b1, 4'd11, 32'h10b, 32'h10c, 1, 2, 1'b1);          // R8 odd dwcas
    do_op(2'd3, 1'b1, 4'd9, 32'h66, 32'h0, 3, 4, 1'b1);              // R8 odd cw2
    do_op(2'd3, 1'b0, 4'd10, 32'h10a, '0, 32'h0, 32'h0, 1'b1);       // R6/R7/R8 readback pair 10,11

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [1:0] op = 2'($urandom);
      logic dw = ($urandom % 4) == 0;
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] cl = ($urandom % 2) ? model[a] : DW'($urandom % 8);
      logic [DW-1:0] ch = ($urandom % 2) ? model[AW'(a + 1)] : DW'($urandom % 8);
      do_op(op, dw, a, cl, ch, DW'($urandom), DW'($urandom), 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule